// File: doc/BRIEF.md
# Crystal Clock Stop and Frequency Window Monitor

This block checks the health of an external crystal clock. It samples the crystal in the reference-clock domain and runs two independent detectors. The stop detector notices that the crystal has halted. The frequency monitor counts crystal rising edges over a fixed gate of reference cycles and tests the result against a programmable 10-bit window.

Each detector has its own enable, its own sticky status flag and its own interrupt enable. A single interrupt request combines the two. Software clears a flag by pulsing its clear input, which is the effect of a write-one-to-clear register bit. All pins are plain level controls or status outputs; the block has no data stream.

Top module: `xmon_top`

## Requirements
- R1: After reset, both flags and the interrupt output are low.
- R2: Rising crystal edges are counted over every window of GATE_CYCLES reference cycles. A window whose count is above the upper bound sets the frequency flag.
- R3: A window whose count is below the lower bound sets the frequency flag. A count between the bounds, inclusive, leaves the flag unchanged.
- R4: The window count saturates at 1023. A crystal with more edges per window than that reads as 1023, so an upper bound of 1023 is never exceeded, while an upper bound of 1022 is.
- R5: The stop flag sets once no synchronised crystal rising edge has been seen for STOP_CYCLES reference cycles. It stays clear while the crystal keeps toggling faster than that.
- R6: The stop condition is a level. While the crystal stays halted, a cleared stop flag sets again.
- R7: A one-cycle clear pulse drops its flag at the next reference edge. If a set event arrives in the same cycle, the set wins and the flag stays high.
- R8: While its enable is low, a detector never sets its flag and never changes a flag that is already set. Software clears still act.
- R9: irq_o is high exactly when (stop_flag and stop_irq_en) or (freq_flag and freq_irq_en). It follows the enables in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xtal_clk | input | 1 | Crystal clock under test, asynchronous to clk |
| stop_det_en | input | 1 | Enables the stop detector |
| freq_det_en | input | 1 | Enables the frequency window monitor |
| stop_irq_en | input | 1 | Lets the stop flag raise the interrupt |
| freq_irq_en | input | 1 | Lets the frequency flag raise the interrupt |
| win_upper | input | 10 | Upper bound of the allowed edge count per window |
| win_lower | input | 10 | Lower bound of the allowed edge count per window |
| stop_flag_clr | input | 1 | Clear pulse for the stop flag |
| freq_flag_clr | input | 1 | Clear pulse for the frequency flag |
| stop_flag | output | 1 | Sticky crystal-stopped flag |
| freq_flag | output | 1 | Sticky frequency-out-of-window flag |
| irq_o | output | 1 | Interrupt request |

## Verification
A crystal edge reaches the detectors three reference cycles after it occurs: two synchroniser stages and one edge register. A window's count is registered at the window's last cycle, and the frequency flag follows one cycle after that. The bench therefore changes the crystal period or bounds, lets at least one full window pass, clears the flag, and samples only after two more complete windows. For the stop flag it samples well before and well after the STOP_CYCLES threshold, never near it. Clear pulses act at the next edge and irq_o is combinational from the flags, so those checks are made at the very next falling edge.

// File: rtl/xmon_pkg.sv
package xmon_pkg;
  localparam int CNT_W = 10;
  localparam int NUM_DET = 2;
  localparam int DET_STOP = 0;
  localparam int DET_FREQ = 1;
  typedef logic [CNT_W-1:0] xcount_t;
  localparam xcount_t CNT_MAX = '1;
endpackage

// File: rtl/xmon_edge_sync.sv
module xmon_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);
  logic [STAGES:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[STAGES-1:0], async_in};
  end

  // shreg[STAGES-1] is the synchronised level, shreg[STAGES] its previous value
  assign rise_o = shreg[STAGES-1] & ~shreg[STAGES];
endmodule

// File: rtl/xmon_window_meter.sv
module xmon_window_meter
  import xmon_pkg::*;
#(
  parameter int GATE_CYCLES = 256
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    edge_i,
  output logic    done_o,
  output xcount_t count_o
);
  localparam int GW = $clog2(GATE_CYCLES);

  logic [GW-1:0] gate_q;
  xcount_t       edges_q;
  xcount_t       edges_nx;
  logic          gate_last;

  assign gate_last = (gate_q == GW'(GATE_CYCLES - 1));
  assign edges_nx  = (edges_q == CNT_MAX) ? edges_q : edges_q + xcount_t'(edge_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q  <= '0;
      edges_q <= '0;
      count_o <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= gate_last;
      if (gate_last) begin
        gate_q  <= '0;
        edges_q <= '0;
        count_o <= edges_nx;
      end else begin
        gate_q  <= gate_q + 1'b1;
        edges_q <= edges_nx;
      end
    end
  end
endmodule

// File: rtl/xmon_idle_timer.sv
module xmon_idle_timer #(
  parameter int STOP_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_i,
  output logic stopped_o
);
  localparam int IW = $clog2(STOP_CYCLES + 1);
  localparam logic [IW-1:0] LIMIT = IW'(STOP_CYCLES);

  logic [IW-1:0] idle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 idle_q <= '0;
    else if (edge_i)            idle_q <= '0;
    else if (idle_q != LIMIT)   idle_q <= idle_q + 1'b1;
  end

  assign stopped_o = (idle_q == LIMIT);
endmodule

// File: rtl/xmon_sticky_flag.sv
module xmon_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic det_en,
  input  logic event_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_o <= 1'b0;
    else        flag_o <= (det_en & event_i) | (flag_o & ~clr_i);
  end
endmodule

// File: rtl/xmon_top.sv
module xmon_top
  import xmon_pkg::*;
#(
  parameter int GATE_CYCLES = 256,
  parameter int STOP_CYCLES = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       xtal_clk,
  input  logic       stop_det_en,
  input  logic       freq_det_en,
  input  logic       stop_irq_en,
  input  logic       freq_irq_en,
  input  logic [9:0] win_upper,
  input  logic [9:0] win_lower,
  input  logic       stop_flag_clr,
  input  logic       freq_flag_clr,
  output logic       stop_flag,
  output logic       freq_flag,
  output logic       irq_o
);
  logic    xtal_rise;
  logic    meas_vld;
  xcount_t meas_cnt;
  logic    stop_cond;
  logic    freq_bad;

  logic [NUM_DET-1:0] det_en, det_evt, det_clr, det_flag, det_ien;

  xmon_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(xtal_clk), .rise_o(xtal_rise)
  );

  xmon_window_meter #(.GATE_CYCLES(GATE_CYCLES)) u_meter (
    .clk(clk), .rst_n(rst_n), .edge_i(xtal_rise),
    .done_o(meas_vld), .count_o(meas_cnt)
  );

  xmon_idle_timer #(.STOP_CYCLES(STOP_CYCLES)) u_idle (
    .clk(clk), .rst_n(rst_n), .edge_i(xtal_rise), .stopped_o(stop_cond)
  );

  assign freq_bad = meas_vld & ((meas_cnt > win_upper) | (meas_cnt < win_lower));

  assign det_en[DET_STOP]  = stop_det_en;
  assign det_en[DET_FREQ]  = freq_det_en;
  assign det_evt[DET_STOP] = stop_cond;
  assign det_evt[DET_FREQ] = freq_bad;
  assign det_clr[DET_STOP] = stop_flag_clr;
  assign det_clr[DET_FREQ] = freq_flag_clr;
  assign det_ien[DET_STOP] = stop_irq_en;
  assign det_ien[DET_FREQ] = freq_irq_en;

  for (genvar gi = 0; gi < NUM_DET; gi++) begin : g_flag
    xmon_sticky_flag u_flag (
      .clk(clk), .rst_n(rst_n), .det_en(det_en[gi]), .event_i(det_evt[gi]),
      .clr_i(det_clr[gi]), .flag_o(det_flag[gi])
    );
  end

  assign stop_flag = det_flag[DET_STOP];
  assign freq_flag = det_flag[DET_FREQ];
  assign irq_o     = |(det_flag & det_ien);
endmodule

// File: rtl/xmon_chk.sv
module xmon_chk (
  input logic clk,
  input logic rst_n,
  input logic stop_det_en,
  input logic freq_det_en,
  input logic stop_irq_en,
  input logic freq_irq_en,
  input logic stop_flag_clr,
  input logic freq_flag_clr,
  input logic stop_flag,
  input logic freq_flag,
  input logic irq_o,
  input logic meas_vld,
  input logic stop_cond
);
  // R8
  stop_rise_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_flag) |-> $past(stop_det_en));
  // R8
  freq_rise_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(freq_flag) |-> $past(freq_det_en));
  // R7
  stop_fall_needs_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_flag) |-> $past(stop_flag_clr));
  // R7
  freq_fall_needs_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(freq_flag) |-> $past(freq_flag_clr));
  // R2
  freq_rise_at_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(freq_flag) |-> $past(meas_vld));
  // R5
  stop_rise_on_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_flag) |-> $past(stop_cond));
  // R2
  window_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    meas_vld |=> !meas_vld);
  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_irq_en && !freq_irq_en) |-> !irq_o);
  // R9
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (stop_flag || freq_flag));
endmodule

bind xmon_top xmon_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stop_det_en(stop_det_en), .freq_det_en(freq_det_en),
  .stop_irq_en(stop_irq_en), .freq_irq_en(freq_irq_en),
  .stop_flag_clr(stop_flag_clr), .freq_flag_clr(freq_flag_clr),
  .stop_flag(stop_flag), .freq_flag(freq_flag), .irq_o(irq_o),
  .meas_vld(meas_vld), .stop_cond(stop_cond)
);

// File: tb/tb_xmon_top.sv
`timescale 1ns/1ps
module tb_xmon_top;
  localparam int GATE = 2048;
  localparam int STOPC = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xtal_clk = 1'b0;
  logic stop_det_en = 0, freq_det_en = 0, stop_irq_en = 0, freq_irq_en = 0;
  logic [9:0] win_upper = 10'd1023, win_lower = 10'd0;
  logic stop_flag_clr = 0, freq_flag_clr = 0;
  logic stop_flag, freq_flag, irq_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  bit xtal_run = 0;
  int half = 4;

  always #2 clk = ~clk;

  xmon_top #(.GATE_CYCLES(GATE), .STOP_CYCLES(STOPC)) dut (
    .clk(clk), .rst_n(rst_n), .xtal_clk(xtal_clk),
    .stop_det_en(stop_det_en), .freq_det_en(freq_det_en),
    .stop_irq_en(stop_irq_en), .freq_irq_en(freq_irq_en),
    .win_upper(win_upper), .win_lower(win_lower),
    .stop_flag_clr(stop_flag_clr), .freq_flag_clr(freq_flag_clr),
    .stop_flag(stop_flag), .freq_flag(freq_flag), .irq_o(irq_o)
  );

  // crystal model: toggles every `half` reference cycles while running
  initial begin
    int hc = 0;
    forever begin
      @(negedge clk);
      if (xtal_run) begin
        hc++;
        if (hc >= half) begin
          xtal_clk = ~xtal_clk;
          hc = 0;
        end
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_freq();
    @(negedge clk); freq_flag_clr = 1;
    @(negedge clk); freq_flag_clr = 0;
  endtask

  function automatic bit exp_irq(bit sf, bit ff, bit se, bit fe);
    return (sf && se) || (ff && fe);
  endfunction

  // settle one window, clear, then observe two full windows
  task automatic measure_fresh();
    cyc(GATE + 60);
    clr_freq();
    cyc(2 * GATE + 20);
  endtask

  initial begin
    void'($urandom(32'd2024));
    cyc(3);
    // R1: reset state
    chk("R1 stop_flag", stop_flag, 0);
    chk("R1 freq_flag", freq_flag, 0);
    chk("R1 irq_o", irq_o, 0);
    rst_n = 1;
    cyc(5);
    chk("R1 flags after release", {stop_flag, freq_flag}, 0);

    // R2: nominal 256 edges per window, inside [240,270]
    half = 4; xtal_run = 1;
    win_lower = 10'd240; win_upper = 10'd270; freq_det_en = 1;
    measure_fresh();
    chk("R3 in-window count leaves flag low", freq_flag, 0);

    // R2: above upper bound
    win_upper = 10'd200;
    cyc(2 * GATE + 20);
    chk("R2 above upper sets flag", freq_flag, 1);
    chk("R9 irq masked", irq_o, 0);
    freq_irq_en = 1;
    cyc(1);
    chk("R9 irq follows enable", irq_o, 1);

    // R7: clear with condition gone
    win_upper = 10'd270;
    clr_freq();
    chk("R7 clear drops flag", freq_flag, 0);
    chk("R9 irq low after clear", irq_o, 0);
    cyc(2 * GATE + 20);
    chk("R7 flag stays clear", freq_flag, 0);

    // R3: below lower bound
    win_lower = 10'd300;
    cyc(2 * GATE + 20);
    chk("R3 below lower sets flag", freq_flag, 1);

    // R8: disabled monitor neither sets nor changes the flag
    freq_det_en = 0;
    cyc(GATE + 20);
    chk("R8 disabled keeps set flag", freq_flag, 1);
    clr_freq();
    cyc(2 * GATE + 20);
    chk("R8 disabled monitor does not set", freq_flag, 0);

    // R4: saturation, 1024 edges per window reads 1023
    half = 1; freq_det_en = 1;
    win_lower = 10'd1000; win_upper = 10'd1023;
    measure_fresh();
    chk("R4 saturated count within 1023 bound", freq_flag, 0);
    win_upper = 10'd1022;
    cyc(2 * GATE + 20);
    chk("R4 saturated count exceeds 1022", freq_flag, 1);

    // R2/R3: random periods and windows
    for (int it = 0; it < 6; it++) begin
      int h, n, mode, r;
      bit expf;
      h = 2 + int'($urandom_range(6));
      n = 1024 / h;
      mode = int'($urandom_range(2));
      r = int'($urandom_range(20));
      half = h;
      if (mode == 0) begin
        win_lower = 10'(n - 5 - r); win_upper = 10'(n + 5 + r); expf = 0;
      end else if (mode == 1) begin
        win_lower = 10'd0; win_upper = 10'(n - 5 - r); expf = 1;
      end else begin
        win_lower = 10'(n + 5 + r); win_upper = 10'd1023; expf = 1;
      end
      measure_fresh();
      chk(mode == 2 ? "R3 random window" : "R2 random window", freq_flag, int'(expf));
      chk("R9 random irq", irq_o, int'(exp_irq(stop_flag, freq_flag, stop_irq_en, freq_irq_en)));
    end

    // R5: running crystal never trips the stop detector
    freq_det_en = 0; clr_freq();
    half = 8; stop_det_en = 1;
    cyc(500);
    chk("R5 running crystal no stop", stop_flag, 0);

    // R5: stop the crystal
    xtal_run = 0;
    cyc(30);
    chk("R5 not yet stopped", stop_flag, 0);
    cyc(90);
    chk("R5 stop detected", stop_flag, 1);
    chk("R9 stop masked", irq_o, int'(exp_irq(1, freq_flag, 0, freq_irq_en)));
    stop_irq_en = 1;
    cyc(1);
    chk("R9 stop irq", irq_o, 1);

    // R6/R7: clear while still halted, set wins
    @(negedge clk); stop_flag_clr = 1;
    @(negedge clk); stop_flag_clr = 0;
    chk("R7 set wins over clear", stop_flag, 1);
    cyc(10);
    chk("R6 level condition reasserts", stop_flag, 1);

    // R8: disabled stop detector does not set
    stop_det_en = 0;
    @(negedge clk); stop_flag_clr = 1;
    @(negedge clk); stop_flag_clr = 0;
    chk("R7 stop clear", stop_flag, 0);
    cyc(200);
    chk("R8 disabled stop detector", stop_flag, 0);

    // R7: clear with crystal running
    stop_det_en = 1;
    cyc(5);
    chk("R5 re-enabled while halted", stop_flag, 1);
    xtal_run = 1; half = 2;
    cyc(20);
    @(negedge clk); stop_flag_clr = 1;
    @(negedge clk); stop_flag_clr = 0;
    cyc(300);
    chk("R7 stop flag stays clear with crystal running", stop_flag, 0);
    chk("R9 irq final", irq_o, int'(exp_irq(stop_flag, freq_flag, stop_irq_en, freq_irq_en)));

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule